// File: doc/BRIEF.md
# ARINC 429 transmit channel

This block sends 32-bit ARINC 429 words onto a pair of return-to-zero lines, one line pulsing for each "1" bit and the other for each "0" bit. The host feeds each message as two 16-bit halves, low half first, over a valid/ready stream. Complete messages wait in an eight-entry queue. Whenever the serializer is idle and a message is waiting, it takes the oldest one. It replaces bit 31 with a parity bit if the programmed mode asks for one, and then shifts the word out, bit 0 first, at a bit time set by a divider input. A quiet gap follows every word.

The stream back-pressure works like this. A half-word transfers on a clock edge where `hw_valid` and `hw_ready` are both high. `hw_ready` falls while the queue holds eight messages. A half-word offered while `hw_ready` is low is dropped, not held, and `ovf_evt` reports it. The read-back port follows the same valid/ready rule. When read-back pops the queue, nothing goes to the serializer.

Three single-cycle event outputs exist: one for the queue draining empty, one for the end of each word, and one for a dropped write. Two controls serve test. One is a queue test mode, which stops new words from starting and exposes the queue head for read-back. The other is a loopback that steers the line pulses to a second pair of outputs, for wiring to a receiver's inputs.

Top module: `a429_tx_chan`

## Requirements
- R1: Immediately after reset the four line outputs are low, `hw_ready` is high, `rb_valid` is low and the three event outputs are low.
- R2: The first accepted half-word of a message supplies bits 15:0 and the second supplies bits 31:16. The message enters the queue on the edge that accepts the second half.
- R3: While eight messages are queued, `hw_ready` is low. A half-word offered while `hw_ready` is low is discarded, leaves the low/high half order unchanged, and makes `ovf_evt` high for exactly the following cycle.
- R4: With H = `rate_div` + 1, each bit lasts 2H clock cycles. In the first H cycles the "1" line is high for a 1 bit, or the "0" line is high for a 0 bit. In the last H cycles both lines are low. The two lines are never high together.
- R5: A word leaves the queue on an edge where the serializer is idle, the queue is non-empty and `test_mode` is low. Its bit 0 starts in the cycle after that edge, and bits follow in ascending order up to bit 31.
- R6: `par_mode` is sampled when a word starts. The encodings are: 0 sends bit 31 as written, 1 sets bit 31 so that the 32 bits hold an odd number of ones, 2 sets it so that they hold an even number, and 3 sends bit 31 as written.
- R7: After the last bit of a word come 8H cycles with both lines low (a four-bit-time gap). Then one idle cycle passes before the next word can start.
- R8: `eot_evt` is high for exactly the first cycle after the last half of bit 31.
- R9: `empty_evt` is high for exactly one cycle, the cycle after an edge that pops the last queued message without accepting a new one.
- R10: While `test_mode` is high, no new word starts. `rb_valid` is high whenever the queue is non-empty, and `rb_data` shows the oldest message. Each `rb_valid`/`rb_ready` transfer removes that message, so messages come out in write order.
- R11: While `loop_en` is high, the pulses appear on `loop_one`/`loop_zero` and `tx_one`/`tx_zero` stay low. While `loop_en` is low, the loop outputs stay low.
- R12: `rate_div` is sampled when a word starts, and a change during the word does not alter that word's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_valid | input | 1 | Half-word offered |
| hw_ready | output | 1 | Queue can take a half-word |
| hw_data | input | 16 | Half-word value |
| par_mode | input | 2 | Parity mode (0 none, 1 odd, 2 even, 3 none) |
| rate_div | input | 8 | Half-bit length minus one, in clocks |
| test_mode | input | 1 | Queue test mode: hold starts, enable read-back |
| loop_en | input | 1 | Route pulses to the loopback pair |
| rb_valid | output | 1 | Read-back head valid |
| rb_ready | input | 1 | Read-back pop request |
| rb_data | output | 32 | Oldest queued message |
| tx_one | output | 1 | Line for "1" bits |
| tx_zero | output | 1 | Line for "0" bits |
| loop_one | output | 1 | Loopback "1" line |
| loop_zero | output | 1 | Loopback "0" line |
| empty_evt | output | 1 | Queue drained to empty |
| eot_evt | output | 1 | Word transmission ended |
| ovf_evt | output | 1 | Half-word dropped on a full queue |

## Verification
Results arrive at fixed distances from their cause:
- `hw_ready`, `rb_valid` and `rb_data` reflect the queue in the same cycle as the edge that changed it.
- `ovf_evt` and `empty_evt` rise one cycle after the edge that caused them.
- Bit i of a word drives its line in cycles 2Hi to 2Hi+H-1, counted from the cycle after the start edge.
- `eot_evt` rises in cycle 64H.

The bench model advances on every rising edge using the inputs sampled there, and the outputs are compared at the falling edge, so each expected value is due in the same cycle it is compared in. A decoder built from the line pulses rebuilds each word, checks its parity bit against a parity function of the bench's own, and measures the quiet time between words.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_RAW  = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_BITS = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_e;

  // Top bit becomes the parity bit over the lower bits when a mode asks for it.
  function automatic logic [WORD_W-1:0] apply_parity(input logic [WORD_W-1:0] w,
                                                     input par_mode_e m);
    logic [WORD_W-1:0] r;
    r = w;
    case (m)
      PAR_ODD:  r[WORD_W-1] = ~(^w[WORD_W-2:0]);
      PAR_EVEN: r[WORD_W-1] = ^w[WORD_W-2:0];
      default:  r[WORD_W-1] = w[WORD_W-1];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_halves.sv
module a429_tx_halves #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid,
  input  logic                  ready,
  input  logic [HALF_W-1:0]     data,
  output logic                  push,
  output logic [2*HALF_W-1:0]   word,
  output logic                  ovf
);
  logic              upper_q;
  logic [HALF_W-1:0] lo_q;
  logic              ovf_q;
  logic              accept;

  assign accept = valid && ready;
  assign push   = accept && upper_q;
  assign word   = {data, lo_q};
  assign ovf    = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= 1'b0;
      lo_q    <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= valid && !ready;
      if (accept) begin
        if (!upper_q) lo_q <= data;
        upper_q <= ~upper_q;
      end
    end
  end
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int GAP_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               avail,
  input  logic [1:0]         par_mode,
  input  logic [DIV_W-1:0]   rate_div,
  input  logic [WORD_W-1:0]  word_in,
  output logic               take,
  output logic               line_one,
  output logic               line_zero,
  output logic               eot,
  output ser_state_e         state
);
  localparam int GAP_HALVES = 2 * GAP_BITS;
  localparam int IDX_W      = $clog2(WORD_W + GAP_HALVES + 1);

  ser_state_e        st_q;
  logic [WORD_W-1:0] sh_q;
  logic [DIV_W-1:0]  div_q, hcnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              phase_q, eot_q;
  logic              half_end, active;

  assign half_end  = (hcnt_q == div_q);
  assign take      = (st_q == SER_IDLE) && avail;
  assign active    = (st_q == SER_BITS) && !phase_q;
  assign line_one  = active && sh_q[0];
  assign line_zero = active && !sh_q[0];
  assign eot       = eot_q;
  assign state     = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SER_IDLE;
      sh_q    <= '0;
      div_q   <= '0;
      hcnt_q  <= '0;
      idx_q   <= '0;
      phase_q <= 1'b0;
      eot_q   <= 1'b0;
    end else begin
      eot_q <= 1'b0;
      case (st_q)
        SER_IDLE: if (avail) begin
          st_q    <= SER_BITS;
          sh_q    <= apply_parity(word_in, par_mode_e'(par_mode));
          div_q   <= rate_div;
          hcnt_q  <= '0;
          phase_q <= 1'b0;
          idx_q   <= '0;
        end
        SER_BITS: if (half_end) begin
          hcnt_q <= '0;
          if (!phase_q) phase_q <= 1'b1;
          else begin
            phase_q <= 1'b0;
            if (idx_q == IDX_W'(WORD_W - 1)) begin
              st_q  <= SER_GAP;
              idx_q <= '0;
              eot_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= sh_q >> 1;
            end
          end
        end else hcnt_q <= hcnt_q + 1'b1;
        SER_GAP: if (half_end) begin
          hcnt_q <= '0;
          if (idx_q == IDX_W'(GAP_HALVES - 1)) st_q <= SER_IDLE;
          else idx_q <= idx_q + 1'b1;
        end else hcnt_q <= hcnt_q + 1'b1;
        default: st_q <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chan.sv
module a429_tx_chan
  import a429_tx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 8,
  parameter int GAP_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_valid,
  output logic                hw_ready,
  input  logic [HALF_W-1:0]   hw_data,
  input  logic [1:0]          par_mode,
  input  logic [DIV_W-1:0]    rate_div,
  input  logic                test_mode,
  input  logic                loop_en,
  output logic                rb_valid,
  input  logic                rb_ready,
  output logic [WORD_W-1:0]   rb_data,
  output logic                tx_one,
  output logic                tx_zero,
  output logic                loop_one,
  output logic                loop_zero,
  output logic                empty_evt,
  output logic                eot_evt,
  output logic                ovf_evt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              asm_push;
  logic [WORD_W-1:0] asm_word, fq_head;
  logic [CNT_W-1:0]  fq_count;
  logic              fq_full, fq_empty, fq_pop, ser_take;
  logic              raw_one, raw_zero, empty_q;
  ser_state_e        ser_st;

  assign hw_ready = !fq_full;
  assign rb_valid = test_mode && !fq_empty;
  assign rb_data  = fq_head;
  assign fq_pop   = ser_take || (rb_valid && rb_ready);

  a429_tx_halves #(.HALF_W(HALF_W)) halves_i (
    .clk(clk), .rst_n(rst_n), .valid(hw_valid), .ready(hw_ready),
    .data(hw_data), .push(asm_push), .word(asm_word), .ovf(ovf_evt)
  );

  a429_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(asm_push), .din(asm_word),
    .pop(fq_pop), .dout(fq_head), .count(fq_count),
    .full(fq_full), .empty(fq_empty)
  );

  a429_tx_ser #(.DIV_W(DIV_W), .GAP_BITS(GAP_BITS)) ser_i (
    .clk(clk), .rst_n(rst_n), .avail(!fq_empty && !test_mode),
    .par_mode(par_mode), .rate_div(rate_div), .word_in(fq_head),
    .take(ser_take), .line_one(raw_one), .line_zero(raw_zero),
    .eot(eot_evt), .state(ser_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b0;
    else        empty_q <= fq_pop && (fq_count == CNT_W'(1)) && !asm_push;
  end
  assign empty_evt = empty_q;

  assign tx_one    = !loop_en && raw_one;
  assign tx_zero   = !loop_en && raw_zero;
  assign loop_one  = loop_en && raw_one;
  assign loop_zero = loop_en && raw_zero;
endmodule

// File: rtl/a429_tx_chan_chk.sv
module a429_tx_chan_chk
  import a429_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hw_valid,
  input logic       hw_ready,
  input logic       test_mode,
  input logic       loop_en,
  input logic       fq_full,
  input logic       fq_empty,
  input logic       fq_pop,
  input logic       raw_one,
  input logic       raw_zero,
  input logic [1:0] ser_st,
  input logic       eot_evt,
  input logic       empty_evt,
  input logic       ovf_evt,
  input logic       tx_one,
  input logic       tx_zero
);
  p_lines_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_one && raw_zero));

  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_st == SER_GAP) |-> (!raw_one && !raw_zero));

  p_eot_after_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_evt |-> ($past(ser_st) == SER_BITS) && (ser_st == SER_GAP));

  p_empty_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> fq_empty);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> $past(hw_valid && !hw_ready));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_full && !fq_pop) |=> fq_full);

  p_test_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_st == SER_IDLE && test_mode) |=> (ser_st != SER_BITS));

  p_loop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!tx_one && !tx_zero));
endmodule

bind a429_tx_chan a429_tx_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
  .test_mode(test_mode), .loop_en(loop_en), .fq_full(fq_full),
  .fq_empty(fq_empty), .fq_pop(fq_pop), .raw_one(raw_one),
  .raw_zero(raw_zero), .ser_st(ser_st), .eot_evt(eot_evt),
  .empty_evt(empty_evt), .ovf_evt(ovf_evt), .tx_one(tx_one),
  .tx_zero(tx_zero)
);

// File: tb/a429_tx_chan_tb_top.sv
`timescale 1ns/1ps
module a429_tx_chan_tb_top;
  localparam int DEPTH = 8;
  localparam int DIV_W = 8;
  localparam int GAPB  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hw_valid, hw_ready, test_mode, loop_en, rb_valid, rb_ready;
  logic [15:0] hw_data;
  logic [1:0]  par_mode;
  logic [DIV_W-1:0] rate_div;
  logic [31:0] rb_data;
  logic tx_one, tx_zero, loop_one, loop_zero, empty_evt, eot_evt, ovf_evt;

  a429_tx_chan #(.DEPTH(DEPTH), .DIV_W(DIV_W), .GAP_BITS(GAPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_data(hw_data), .par_mode(par_mode), .rate_div(rate_div),
    .test_mode(test_mode), .loop_en(loop_en), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .rb_data(rb_data), .tx_one(tx_one), .tx_zero(tx_zero),
    .loop_one(loop_one), .loop_zero(loop_zero), .empty_evt(empty_evt),
    .eot_evt(eot_evt), .ovf_evt(ovf_evt)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] par_ref(input logic [31:0] w, input logic [1:0] m);
    int ones;
    logic [31:0] r;
    ones = 0;
    r = w;
    for (int i = 0; i < 31; i++) ones += int'(w[i]);
    if (m == 2'd1) r[31] = (ones % 2 == 0);
    else if (m == 2'd2) r[31] = (ones % 2 == 1);
    return r;
  endfunction

  // Behavioural reference: queue of messages plus a time-in-word counter.
  logic [31:0] mq[$];
  logic [31:0] sent_q[$];
  int          sent_h[$];
  bit          m_upper, m_empty, m_ovf;
  logic [15:0] m_lo;
  int          ms, mk, mh;
  logic [31:0] mw;

  int          sz;
  bit          rdy, start, rbpop, acc, push;
  logic [31:0] nw;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); sent_q.delete(); sent_h.delete();
      m_upper = 0; m_empty = 0; m_ovf = 0; m_lo = '0;
      ms = 0; mk = 0; mh = 1; mw = '0;
    end else begin
      sz    = mq.size();
      rdy   = (sz < DEPTH);
      start = (ms == 0) && (sz > 0) && !test_mode;
      rbpop = test_mode && (sz > 0) && rb_ready;
      acc   = hw_valid && rdy;
      push  = acc && m_upper;
      nw    = {hw_data, m_lo};
      m_ovf   = hw_valid && !rdy;
      m_empty = (start || rbpop) && (sz == 1) && !push;
      if (acc) begin
        if (!m_upper) m_lo = hw_data;
        m_upper = !m_upper;
      end
      case (ms)
        1: if (mk == 64 * mh - 1) begin ms = 2; mk = 0; end else mk++;
        2: if (mk == 2 * GAPB * mh - 1) begin ms = 0; mk = 0; end else mk++;
        default: if (start) begin
          mw = par_ref(mq[0], par_mode);
          mh = int'(rate_div) + 1;
          ms = 1; mk = 0;
          sent_q.push_back(mw);
          sent_h.push_back(mh);
        end
      endcase
      if (start || rbpop) void'(mq.pop_front());
      if (push) mq.push_back(nw);
    end
  end

  // Per-cycle comparison at the falling edge.
  bit e_one, e_zero, act_ph, b;
  string ltag;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      e_one = 0; e_zero = 0;
      if (ms == 1) begin
        b      = mw[mk / (2 * mh)];
        act_ph = (mk % (2 * mh)) < mh;
        e_one  = act_ph && b;
        e_zero = act_ph && !b;
      end
      ltag = (ms == 1) ? "R4 R5 R12 R11" : "R7 R11";
      chk(tx_one == (!loop_en && e_one) && tx_zero == (!loop_en && e_zero),
          ltag, {tx_one, tx_zero}, {!loop_en && e_one, !loop_en && e_zero});
      chk(loop_one == (loop_en && e_one) && loop_zero == (loop_en && e_zero),
          "R11 loop lines", {loop_one, loop_zero}, {loop_en && e_one, loop_en && e_zero});
      chk(eot_evt == (ms == 2 && mk == 0), "R8 eot", eot_evt, (ms == 2 && mk == 0));
      chk(empty_evt == m_empty, "R9 empty event", empty_evt, m_empty);
      chk(ovf_evt == m_ovf, "R3 overflow event", ovf_evt, m_ovf);
      chk(hw_ready == (mq.size() < DEPTH), "R3 ready", hw_ready, (mq.size() < DEPTH));
      chk(rb_valid == (test_mode && mq.size() > 0), "R10 rb_valid", rb_valid,
          (test_mode && mq.size() > 0));
      if (rb_valid && mq.size() > 0)
        chk(rb_data == mq[0], "R10 R2 rb_data", rb_data, mq[0]);
    end
  end

  // Line decoder: rebuilds words and measures the quiet time between them.
  int cap_n = 0, quiet = 0, last_h = 1;
  bit seen_word = 0, prev_act = 0, lo_, lz_;
  logic [31:0] cap_w, ew;
  always @(negedge clk) begin
    if (!rst_n) begin
      cap_n = 0; quiet = 0; seen_word = 0; prev_act = 0;
    end else if (!finished) begin
      lo_ = tx_one || loop_one;
      lz_ = tx_zero || loop_zero;
      if ((lo_ || lz_) && !prev_act) begin
        if (cap_n == 0 && seen_word)
          chk(quiet >= 9 * last_h + 1, "R7 inter-word gap", quiet, 9 * last_h + 1);
        cap_w[cap_n] = lo_;
        cap_n++;
        if (cap_n == 32) begin
          cap_n = 0;
          seen_word = 1;
          ew = (sent_q.size() > 0) ? sent_q.pop_front() : 32'hdead_beef;
          last_h = (sent_h.size() > 0) ? sent_h.pop_front() : 1;
          chk(cap_w == ew, "R2 R5 R6 decoded word", cap_w, ew);
        end
      end
      if (lo_ || lz_) quiet = 0; else quiet++;
      prev_act = lo_ || lz_;
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_half(input logic [15:0] d);
    while (!hw_ready) step();
    hw_valid = 1; hw_data = d;
    step();
    hw_valid = 0;
  endtask

  task automatic send_word(input logic [31:0] w);
    send_half(w[15:0]);
    send_half(w[31:16]);
  endtask

  task automatic force_half(input logic [15:0] d);
    hw_valid = 1; hw_data = d;
    step();
    hw_valid = 0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while ((mq.size() != 0 || ms != 0) && n < 20000) begin step(); n++; end
    repeat (3) step();
  endtask

  task automatic read_one(input logic [31:0] exp);
    @(negedge clk);
    chk(rb_valid && rb_data == exp, "R10 read-back order", rb_data, exp);
    #1; rb_ready = 1;
    step();
    rb_ready = 0;
  endtask

  initial begin
    rst_n = 0; hw_valid = 0; hw_data = '0; par_mode = 2'd0; rate_div = '0;
    test_mode = 0; loop_en = 0; rb_ready = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!tx_one && !tx_zero && !loop_one && !loop_zero, "R1 lines after reset",
        {tx_one, tx_zero, loop_one, loop_zero}, 4'h0);
    chk(hw_ready && !rb_valid, "R1 ready/rb_valid after reset", {hw_ready, rb_valid}, 2'b10);
    chk(!empty_evt && !eot_evt && !ovf_evt, "R1 events after reset",
        {empty_evt, eot_evt, ovf_evt}, 3'h0);
    step();

    // No parity, fastest rate, back-to-back words.
    send_word(32'h8000_0abc);
    send_word(32'h1234_5678);
    wait_idle();

    // R6 odd parity, H=2.
    par_mode = 2'd1; rate_div = 8'd1;
    send_word(32'h0000_0001);
    send_word(32'hffff_ffff);
    send_word(32'h0000_0000);
    wait_idle();

    // R6 even parity and mode 3, H=3.
    par_mode = 2'd2; rate_div = 8'd2;
    send_word(32'h7000_0003);
    send_word(32'h8000_0000);
    wait_idle();
    par_mode = 2'd3;
    send_word(32'h8000_0001);
    wait_idle();

    // R3 full queue and dropped halves; R10 read-back; R11 loopback drain.
    par_mode = 2'd0; rate_div = 8'd0; test_mode = 1;
    for (int i = 0; i < DEPTH; i++) send_word(32'h0101_0101 * (i + 1));
    @(negedge clk);
    chk(!hw_ready, "R3 ready low when full", hw_ready, 1'b0);
    #1;
    force_half(16'hbad0);
    force_half(16'hbad1);
    read_one(32'h0101_0101);
    read_one(32'h0202_0202);
    send_word(32'hc0de_5a5a);
    loop_en = 1; test_mode = 0;
    wait_idle();
    loop_en = 0;

    // R12 rate change inside a word.
    rate_div = 8'd3;
    send_word(32'h5555_aaaa);
    while (!(ms == 1 && mk >= 20)) step();
    rate_div = 8'd0;
    wait_idle();
    send_word(32'h0f0f_f0f0);
    wait_idle();

    summary();
  end
endmodule